// File: doc/BRIEF.md
# Configurable Registered Output Macrocell Bank

This block is a bank of output macrocells that sit behind a programmable logic array. Each cell takes four terms from the array: a data sum term, an enable sum term, the array's shared reset product term, and a per-cell output-enable product term. Configuration inputs put each cell in one of three modes. In combinational mode the register is bypassed. In edge-clock mode a D register is clocked by the rising edge of the polarity-adjusted enable term itself. In clock-enable mode a D register is clocked by the common output clock and the enable term gates each load, which gives counters and state machines a hold condition.

Each cell has its own polarity bit for the enable term and its own polarity bit for the pin. A pin-connected cell drives its pad through an inverting buffer under control of its output-enable term. The cell returns two kinds of feedback to the array. The first is the cell value taken before the polarity stage, in both true and complement form. The second is the pad level read back, so a pin whose driver is disabled can still act as an input. A parameter builds the whole bank as buried cells. Buried cells have no pad path, and the array picks their polarity from the true or the complement feedback.

Top module: `macro_bank`

## Requirements
- R1: A cell whose mode code is 2'b00 or 2'b11 is combinational: its true feedback equals its data term in the same cycle, and no register affects it.
- R2: A cell with mode code 2'b01 loads the data term into its register on each rising edge of its effective enable. Edges of `clk` have no effect on it.
- R3: A cell with mode code 2'b10 loads the data term on a rising edge of `clk` when its effective enable is 1.
- R4: A cell with mode code 2'b10 keeps its register value across a rising edge of `clk` when its effective enable is 0.
- R5: The effective enable of each cell is its enable term XOR its `cfg_e_inv` bit.
- R6: While `rst` is 1, every register of every cell is 0 at once, without waiting for a clock. Reset wins over any clock or enable edge.
- R7: A pin-connected cell drives `pin_out` = NOT(value XOR `cfg_o_inv`). A cell whose register is cleared and whose polarity bit is 0 therefore drives 1.
- R8: On a pin-connected cell, `pin_oe` follows that cell's output-enable term.
- R9: `fb_true` carries the cell value taken before the polarity and buffer stages (the register in modes 01 and 10, the data term otherwise). `fb_comp` is its complement.
- R10: On a pin-connected cell, `fb_pin` returns the pad level `pin_in` in every mode.
- R11: With BURIED=1, `pin_out`, `pin_oe` and `fb_pin` are held at 0, while `fb_true` and `fb_comp` still behave as in R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common output clock for clock-enable mode |
| rst | input | 1 | Shared reset product term, active high, asynchronous |
| d_term | input | N_CELL | Data sum term, one per cell |
| e_term | input | N_CELL | Enable sum term, one per cell |
| oe_term | input | N_CELL | Output-enable product term, one per cell |
| cfg_mode | input | 2*N_CELL | Mode code per cell, two bits each, cell 0 lowest |
| cfg_e_inv | input | N_CELL | Enable polarity bit per cell |
| cfg_o_inv | input | N_CELL | Pin polarity bit per cell |
| pin_in | input | N_CELL | Pad level read back from each pin |
| pin_out | output | N_CELL | Level driven toward each pad (after inversion) |
| pin_oe | output | N_CELL | Pad driver enable per cell |
| fb_true | output | N_CELL | True internal feedback per cell |
| fb_comp | output | N_CELL | Complement internal feedback per cell |
| fb_pin | output | N_CELL | Pad feedback per cell |

## Verification
Four properties are checked on every cycle of the common clock: the register clears while reset is high, the clock-enable register holds when the effective enable is low and loads when it is high, and combinational cells pass their data straight through. The level a cleared register puts on the pin is also checked whenever reset is high. The edge-clock register runs off the enable term rather than `clk`, so its behaviour can only be shown by the bench. The bench raises the effective enable, holds it high across clock edges, and flips the enable polarity. It also shows the asynchronous clear landing between clock edges, the pad feedback path, and the buried build, using its own model.

// File: rtl/macro_pkg.sv
package macro_pkg;

    typedef enum logic [1:0] {
        MC_COMB     = 2'b00,
        MC_ECLK     = 2'b01,
        MC_DEREG    = 2'b10,
        MC_COMB_ALT = 2'b11
    } mc_mode_e;

    typedef struct packed {
        mc_mode_e mode;
        logic     e_inv;
        logic     o_inv;
    } mc_cfg_t;

    function automatic logic pad_level(input logic core, input logic o_inv);
        return ~(core ^ o_inv);
    endfunction

    function automatic logic is_registered(input mc_mode_e m);
        return (m == MC_ECLK) || (m == MC_DEREG);
    endfunction

endpackage

// File: rtl/mc_e_polarity.sv
module mc_e_polarity (
    input  logic e_term,
    input  logic e_inv,
    output logic e_eff
);
    // R5: programmable polarity on the enable sum term
    assign e_eff = e_term ^ e_inv;
endmodule

// File: rtl/mc_store.sv
module mc_store
    import macro_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     d,
    input  logic     e_eff,
    input  mc_mode_e mode,
    output logic     core
);
    logic q_de;
    logic q_ec;

    // Clock-enable register on the common clock
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            q_de <= 1'b0;
        else if (e_eff)
            q_de <= d;
    end

    // Edge-clock register: the enable term itself is the clock
    always_ff @(posedge e_eff or posedge rst) begin
        if (rst)
            q_ec <= 1'b0;
        else
            q_ec <= d;
    end

    always_comb begin
        unique case (mode)
            MC_ECLK:  core = q_ec;
            MC_DEREG: core = q_de;
            default:  core = d;
        endcase
    end

    a_r4_de_hold: assert property (@(posedge clk) disable iff (rst)
        !e_eff |=> (q_de == $past(q_de)));

    a_r3_de_load: assert property (@(posedge clk) disable iff (rst)
        e_eff |=> (q_de == $past(d)));

    a_r6_reset_clear: assert property (@(posedge clk)
        rst |-> (q_de == 1'b0 && q_ec == 1'b0));

endmodule

// File: rtl/mc_pin_stage.sv
module mc_pin_stage
    import macro_pkg::*;
#(
    parameter bit BURIED = 1'b0
) (
    input  logic core,
    input  logic o_inv,
    input  logic oe,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_fb
);
    generate
        if (BURIED) begin : g_buried
            logic unused_sink;
            assign unused_sink = ^{core, o_inv, oe, pad_in};
            assign pad_out = 1'b0;
            assign pad_oe  = 1'b0;
            assign pad_fb  = 1'b0;
        end else begin : g_pinned
            assign pad_out = pad_level(core, o_inv);
            assign pad_oe  = oe;
            assign pad_fb  = pad_in;
        end
    endgenerate
endmodule

// File: rtl/macro_bank.sv
module macro_bank
    import macro_pkg::*;
#(
    parameter int N_CELL = 4,
    parameter bit BURIED = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_CELL-1:0]     d_term,
    input  logic [N_CELL-1:0]     e_term,
    input  logic [N_CELL-1:0]     oe_term,
    input  logic [2*N_CELL-1:0]   cfg_mode,
    input  logic [N_CELL-1:0]     cfg_e_inv,
    input  logic [N_CELL-1:0]     cfg_o_inv,
    input  logic [N_CELL-1:0]     pin_in,
    output logic [N_CELL-1:0]     pin_out,
    output logic [N_CELL-1:0]     pin_oe,
    output logic [N_CELL-1:0]     fb_true,
    output logic [N_CELL-1:0]     fb_comp,
    output logic [N_CELL-1:0]     fb_pin
);
    localparam int MODE_W = $bits(mc_mode_e);

    generate
        for (genvar i = 0; i < N_CELL; i++) begin : g_cell
            mc_cfg_t cfg;
            logic    e_eff;
            logic    core;

            assign cfg.mode  = mc_mode_e'(cfg_mode[i*MODE_W +: MODE_W]);
            assign cfg.e_inv = cfg_e_inv[i];
            assign cfg.o_inv = cfg_o_inv[i];

            mc_e_polarity u_pol (
                .e_term (e_term[i]),
                .e_inv  (cfg.e_inv),
                .e_eff  (e_eff)
            );

            mc_store u_store (
                .clk   (clk),
                .rst   (rst),
                .d     (d_term[i]),
                .e_eff (e_eff),
                .mode  (cfg.mode),
                .core  (core)
            );

            mc_pin_stage #(.BURIED(BURIED)) u_pin (
                .core    (core),
                .o_inv   (cfg.o_inv),
                .oe      (oe_term[i]),
                .pad_in  (pin_in[i]),
                .pad_out (pin_out[i]),
                .pad_oe  (pin_oe[i]),
                .pad_fb  (fb_pin[i])
            );

            assign fb_true[i] = core;
            assign fb_comp[i] = ~core;

            a_r1_comb_pass: assert property (@(posedge clk) disable iff (rst)
                !is_registered(cfg.mode) |-> (fb_true[i] == d_term[i]));

            if (!BURIED) begin : g_rst_pin
                a_r7_reset_pin_high: assert property (@(posedge clk)
                    (rst && is_registered(cfg.mode) && !cfg.o_inv) |-> pin_out[i]);
            end
        end
    endgenerate

endmodule

// File: tb/macro_bank_tb_top.sv
module macro_bank_tb_top;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   d = '0, e = '0, oe = '0, pin_in = '0;
    logic [N-1:0]   einv = '0, oinv = '0;
    logic [2*N-1:0] mode = {N{2'b10}};
    logic [N-1:0]   p_out, p_oe, f_t, f_c, f_p;
    logic [N-1:0]   b_out, b_oe, b_t, b_c, b_p;
    logic [N-1:0]   mq_de = '0, mq_ec = '0;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    macro_bank #(.N_CELL(N), .BURIED(1'b0)) dut_i (
        .clk(clk), .rst(rst), .d_term(d), .e_term(e), .oe_term(oe),
        .cfg_mode(mode), .cfg_e_inv(einv), .cfg_o_inv(oinv), .pin_in(pin_in),
        .pin_out(p_out), .pin_oe(p_oe), .fb_true(f_t), .fb_comp(f_c), .fb_pin(f_p));

    macro_bank #(.N_CELL(N), .BURIED(1'b1)) bur_i (
        .clk(clk), .rst(rst), .d_term(d), .e_term(e), .oe_term(oe),
        .cfg_mode(mode), .cfg_e_inv(einv), .cfg_o_inv(oinv), .pin_in(pin_in),
        .pin_out(b_out), .pin_oe(b_oe), .fb_true(b_t), .fb_comp(b_c), .fb_pin(b_p));

    function automatic logic [1:0] mode_of(input int i);
        return mode[2*i +: 2];
    endfunction

    function automatic logic exp_core(input int i);
        case (mode_of(i))
            2'b01:   return mq_ec[i];
            2'b10:   return mq_de[i];
            default: return d[i];
        endcase
    endfunction

    function automatic string core_req(input int i);
        case (mode_of(i))
            2'b01:   return "R2";
            2'b10:   return ((e[i] ^ einv[i]) ? "R3" : "R4");
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp_v);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < N; i++) begin
            logic c;
            c = exp_core(i);
            chk(core_req(i), f_t[i], c);
            chk("R9", f_c[i], ~c);
            chk("R7", p_out[i], ~(c ^ oinv[i]));
            chk("R8", p_oe[i], oe[i]);
            chk("R10", f_p[i], pin_in[i]);
            chk("R11", b_out[i], 1'b0);
            chk("R11", b_oe[i], 1'b0);
            chk("R11", b_p[i], 1'b0);
            chk("R11", b_t[i], c);
            chk("R11", b_c[i], ~c);
        end
    endtask

    task automatic set_e(input logic [N-1:0] ne);
        for (int i = 0; i < N; i++)
            if (!rst && !(e[i] ^ einv[i]) && (ne[i] ^ einv[i]))
                mq_ec[i] = d[i];
        e = ne;
    endtask

    // Called just after a falling edge
    task automatic step(input logic [N-1:0] nd, input logic [N-1:0] ne,
                        input logic [N-1:0] noe, input logic [N-1:0] npin);
        d = nd; oe = noe; pin_in = npin;
        #1;
        set_e(ne);
        @(posedge clk);
        for (int i = 0; i < N; i++)
            if (!rst && (e[i] ^ einv[i])) mq_de[i] = d[i];
        @(negedge clk);
        check_all();
    endtask

    task automatic new_phase(input logic [2*N-1:0] nm, input logic [N-1:0] nei,
                             input logic [N-1:0] noi);
        rst = 1'b1;
        mode = nm; einv = nei; oinv = noi;
        mq_de = '0; mq_ec = '0;
        @(posedge clk);
        @(negedge clk);
        check_all();  // R6: cleared registers under reset
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        @(negedge clk);
        // R6 R7: reset state, all cells clock-enable mode, polarity 0 -> pins high
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            chk("R6", f_t[i], 1'b0);
            chk("R7", p_out[i], 1'b1);
        end
        rst = 1'b0;

        // R3 then R4: load ones, then hold with enable low while data drops
        step('1, '1, '1, '0);
        for (int k = 0; k < 3; k++) begin
            step('0, '0, '1, '1);
            for (int i = 0; i < N; i++) chk("R4", f_t[i], 1'b1);
        end

        // R5: inverted enable polarity, term low means enabled
        new_phase({N{2'b10}}, '1, '0);
        step(4'b1010, '0, '0, '0);
        chk("R5", f_t[1], 1'b1);
        chk("R5", f_t[0], 1'b0);

        // R2: edge-clock mode, enable held high across clock edges ignores data
        new_phase({N{2'b01}}, '0, 4'b0101);
        step('1, '1, '0, '0);
        step('0, '1, '0, '0);
        step('0, '1, '0, '0);
        for (int i = 0; i < N; i++) chk("R2", f_t[i], 1'b1);

        // R6: asynchronous clear between clock edges
        #1 rst = 1'b1;
        #1;
        for (int i = 0; i < N; i++) chk("R6", f_t[i], 1'b0);
        mq_ec = '0; mq_de = '0;
        @(posedge clk);
        // R6: enable edge while reset is high is ignored
        set_e('0);
        #1 set_e('1);
        @(negedge clk);
        for (int i = 0; i < N; i++) chk("R6", f_t[i], 1'b0);
        rst = 1'b0;

        // R1: mode codes 00 and 11 pass data
        new_phase({2'b11, 2'b00, 2'b11, 2'b00}, '0, 4'b0011);
        step(4'b0110, '0, 4'b1100, 4'b1001);
        step(4'b1001, '1, 4'b0011, 4'b0110);

        // Randomised phases
        for (int p = 0; p < 20; p++) begin
            new_phase(N'($urandom) == 0 ? '0 : 8'($urandom), 4'($urandom), 4'($urandom));
            for (int s = 0; s < 30; s++)
                step(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule